// File: doc/BRIEF.md
# Host clock prescaler

This block turns a 16 MHz reference clock into a clock for a host microcontroller. A 3-bit rate code picks one of eight output frequencies: 16 MHz, 8 MHz, 4 MHz, 2 MHz, 1 MHz, 62.5 kHz, about 32.786 kHz and about 16.393 kHz. For every divisor of two or more the output is a registered square wave. For divisor one the reference itself is gated through.

The output runs while the run condition holds. The run condition is true when `clk_en` is high and either `doze_active` is low or `doze_run_en` is high. Changes to the rate code and to the run condition are sampled only when a low phase of the output completes. So a reprogramming never produces a shortened high or low pulse, and stopping always parks the output low. The control register that drives these pins lives elsewhere. Its reset value for the rate code is 6. The block has no data stream, so all pins are plain level controls.

Top module: `host_clk_prescaler`

## Requirements
- R1: While `rst_n` is low, `host_clk` is low. After reset it stays low for as long as `clk_en` is low.
- R2: Rate codes 0..7 select divisors 1, 2, 4, 8, 16, 256, 488 and 976. For a divisor N of 2 or more, every high phase and every low phase lasts exactly N reference half-periods (N/2 reference cycles).
- R3: With code 0 running, `host_clk` is high exactly during the high half of each reference cycle and low during the low half.
- R4: `rate_sel` is sampled only when a low phase ends. A change made during a high or low phase leaves that phase and the next low phase at the old length. The following pulse uses the new divisor.
- R5: When `clk_en` drops, no high phase is cut short. With N of 2 or more, no new high phase starts after the current low phase ends. With N = 1, the pulse already due at the next rising reference edge still appears, and then the output stops low.
- R6: `doze_active` high with `doze_run_en` low stops the output exactly as in R5. With `doze_run_en` high, the output keeps running through doze.
- R7: From the stopped state, when the run condition becomes true, a divisor of 2 or more raises `host_clk` at the next rising reference edge. Divisor 1 gives its first pulse one reference cycle later.
- R8: The divider register and the pass-through gate are never enabled together.
  - A switch from divisor 1 to N makes the next pulse exactly N half-periods long.
  - A switch from N to divisor 1 stretches the last low phase to N+2 half-periods.
  - No phase of either switch is shorter than one half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code, 0..7 (see R2) |
| clk_en | input | 1 | Output enable |
| doze_run_en | input | 1 | Keep the output running while in doze |
| doze_active | input | 1 | Chip is in the doze low-power state |
| host_clk | output | 1 | Divided clock for the host |

## Verification
Every result is due at a fixed reference edge:
- For divisor N of 2 or more, a pulse starts at the rising edge that ends a low phase. It lasts N half-periods.
- After a stop request, no new pulse appears.
- Divisor 1 lags a decision by one reference cycle.

The monitor samples `host_clk` one nanosecond after every reference edge. It counts phase lengths in half-periods and pops the expected high and low lengths that the driver queued. The driver changes inputs only in the sample slot right after the monitor sees a rise or a fall. This places each change at a known point in the phase. It also fixes which edge first sees the change.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int RATE_W    = 3;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int HALF_MAX  = 488;
  localparam int CNT_W     = $clog2(HALF_MAX + 1);

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [CNT_W-1:0]  half_t;

  localparam rate_t RATE_RESET  = rate_t'(6);
  localparam rate_t RATE_BYPASS = rate_t'(0);

  // Reference cycles per output half period; zero marks the pass-through code.
  function automatic half_t half_of(input rate_t code);
    half_t h;
    case (code)
      rate_t'(1): h = half_t'(1);
      rate_t'(2): h = half_t'(2);
      rate_t'(3): h = half_t'(4);
      rate_t'(4): h = half_t'(8);
      rate_t'(5): h = half_t'(128);
      rate_t'(6): h = half_t'(244);
      rate_t'(7): h = half_t'(488);
      default:    h = half_t'(0);
    endcase
    return h;
  endfunction
endpackage

// File: rtl/pscl_ratio_lut.sv
module pscl_ratio_lut
  import pscl_pkg::*;
(
  input  rate_t code,
  output half_t half,
  output logic  bypass
);
  always_comb begin
    half   = half_of(code);
    bypass = (code == RATE_BYPASS);
  end
endmodule

// File: rtl/pscl_run_qual.sv
module pscl_run_qual (
  input  logic clk_en,
  input  logic doze_active,
  input  logic doze_run_en,
  output logic run_ok
);
  always_comb run_ok = clk_en & (~doze_active | doze_run_en);
endmodule

// File: rtl/pscl_phase_ctrl.sv
module pscl_phase_ctrl
  import pscl_pkg::*;
(
  input  logic  ref_clk,
  input  logic  rst_n,
  input  rate_t rate_sel,
  input  logic  run_ok,
  output logic  div_q,
  output logic  arm,
  output logic  running,
  output rate_t act,
  output half_t cnt
);
  half_t half_cur;
  logic  act_bypass;
  half_t unused_half;
  logic  new_bypass;
  logic  last_tick;
  logic  bnd;

  pscl_ratio_lut u_cur_lut (.code(act),      .half(half_cur),    .bypass(act_bypass));
  pscl_ratio_lut u_new_lut (.code(rate_sel), .half(unused_half), .bypass(new_bypass));

  always_comb begin
    last_tick = (cnt == half_t'(half_cur - half_t'(1)));
    // A boundary is any edge where a new high phase may begin.
    bnd       = ~running | act_bypass | (~div_q & last_tick);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      arm     <= 1'b0;
      running <= 1'b0;
      act     <= RATE_RESET;
      cnt     <= '0;
    end else if (bnd) begin
      cnt <= '0;
      if (!run_ok) begin
        running <= 1'b0;
        div_q   <= 1'b0;
        arm     <= 1'b0;
      end else if (new_bypass) begin
        running <= 1'b1;
        act     <= rate_sel;
        div_q   <= 1'b0;
        arm     <= 1'b1;
      end else begin
        running <= 1'b1;
        act     <= rate_sel;
        div_q   <= 1'b1;
        arm     <= 1'b0;
      end
    end else if (last_tick) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else begin
      cnt <= cnt + half_t'(1);
    end
  end
endmodule

// File: rtl/pscl_out_stage.sv
module pscl_out_stage (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic arm,
  input  logic div_q,
  output logic gate,
  output logic host_clk
);
  // Gate changes only while the reference is low, so the AND never slivers.
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= arm;
  end

  assign host_clk = div_q | (ref_clk & gate);
endmodule

// File: rtl/host_clk_prescaler.sv
module host_clk_prescaler
  import pscl_pkg::*;
(
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              clk_en,
  input  logic              doze_run_en,
  input  logic              doze_active,
  output logic              host_clk
);
  logic  run_ok;
  logic  div_q;
  logic  arm;
  logic  gate;
  logic  running;
  rate_t act;
  half_t cnt;

  pscl_run_qual u_run_qual (
    .clk_en      (clk_en),
    .doze_active (doze_active),
    .doze_run_en (doze_run_en),
    .run_ok      (run_ok)
  );

  pscl_phase_ctrl u_phase_ctrl (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .run_ok   (run_ok),
    .div_q    (div_q),
    .arm      (arm),
    .running  (running),
    .act      (act),
    .cnt      (cnt)
  );

  pscl_out_stage u_out_stage (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .div_q    (div_q),
    .gate     (gate),
    .host_clk (host_clk)
  );
endmodule

// File: rtl/pscl_checker.sv
module pscl_checker
  import pscl_pkg::*;
(
  input logic  ref_clk,
  input logic  rst_n,
  input logic  clk_en,
  input logic  doze_active,
  input logic  doze_run_en,
  input logic  host_clk,
  input logic  div_q,
  input logic  arm,
  input logic  gate,
  input logic  running,
  input rate_t act,
  input half_t cnt
);
  logic may_run;
  assign may_run = clk_en & (~doze_active | doze_run_en);

  // R1
  always @(negedge ref_clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (host_clk == 1'b0);
  end

  a_r2_cnt_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (running && act != RATE_BYPASS) |-> (cnt < half_of(act)));

  a_r4_rate_held_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (div_q && $past(div_q)) |-> (act == $past(act)));

  a_r5_stopped_stays_low: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!clk_en && !running) |=> (!running && !div_q && !arm));

  a_r6_doze_holds_low: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (doze_active && !doze_run_en && !running) |=> (!div_q && !arm));

  a_r7_restart: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!running && may_run) |=> (div_q || arm));

  a_r8_one_source: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0({div_q, gate}));
endmodule

bind host_clk_prescaler pscl_checker u_pscl_checker (
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .doze_active (doze_active),
  .doze_run_en (doze_run_en),
  .host_clk    (host_clk),
  .div_q       (div_q),
  .arm         (arm),
  .gate        (gate),
  .running     (running),
  .act         (act),
  .cnt         (cnt)
);

// File: tb/test_host_clk_prescaler.sv
`timescale 1ns/1ps
module test_host_clk_prescaler;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       clk_en;
  logic       doze_run_en;
  logic       doze_active;
  logic       host_clk;

  int n_chk  = 0;
  int n_fail = 0;
  int fall_cnt = 0;
  int rise_cnt = 0;
  int    hi_q[$];
  int    lo_q[$];
  string rq_q[$];
  int div_tab[8] = '{1, 2, 4, 8, 16, 256, 488, 976};

  always #2 ref_clk = ~ref_clk;

  host_clk_prescaler i_host_clk_prescaler (
    .ref_clk(ref_clk), .rst_n(rst_n), .rate_sel(rate_sel), .clk_en(clk_en),
    .doze_run_en(doze_run_en), .doze_active(doze_active), .host_clk(host_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int hi, input int lo, input string req);
    hi_q.push_back(hi);
    lo_q.push_back(lo);
    rq_q.push_back(req);
  endtask

  task automatic wait_fall(input int n);
    int t;
    t = fall_cnt + n;
    wait (fall_cnt >= t);
  endtask

  task automatic quiet(input int cycles, input string req);
    repeat (cycles) @(negedge ref_clk);
    #1;
    check(host_clk == 1'b0, req, int'(host_clk), 0);
    check(hi_q.size() == 0, req, hi_q.size(), 0);
  endtask

  // Monitor: phase lengths in reference half-periods.
  initial begin
    bit prev;
    int run;
    bit have;
    int cur_hi;
    int cur_lo;
    string cur_r;
    prev = 1'b0; run = 0; have = 1'b0; cur_hi = 0; cur_lo = 0; cur_r = "";
    forever begin
      @(ref_clk);
      #1;
      if (host_clk === prev) run++;
      else begin
        if (prev) begin
          if (have) check(run == cur_hi, {cur_r, " high"}, run, cur_hi);
          fall_cnt++;
        end else begin
          if (have && cur_lo != 0) check(run == cur_lo, {cur_r, " low"}, run, cur_lo);
          if (hi_q.size() == 0) begin
            check(1'b0, "R5 unexpected pulse", 1, 0);
            have = 1'b0;
          end else begin
            cur_hi = hi_q.pop_front();
            cur_lo = lo_q.pop_front();
            cur_r  = rq_q.pop_front();
            have   = 1'b1;
          end
          rise_cnt++;
        end
        run  = 1;
        prev = host_clk;
      end
    end
  end

  task automatic run_code(input int code, input string req);
    int nd;
    int base;
    nd = div_tab[code];
    rate_sel = 3'(code);
    for (int k = 0; k < 3; k++) push(nd, (k == 2) ? 0 : nd, req);
    base = fall_cnt;
    clk_en = 1'b1;
    wait (fall_cnt >= base + ((nd == 1) ? 2 : 3));
    clk_en = 1'b0;
    quiet(nd + 8, "R5");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog R1-all: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; clk_en = 1'b0; doze_run_en = 1'b0; doze_active = 1'b0; rate_sel = 3'd6;
    repeat (4) @(negedge ref_clk);
    #1;
    check(host_clk == 1'b0, "R1 in reset", int'(host_clk), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge ref_clk);
    #1;
    check(host_clk == 1'b0, "R1 idle", int'(host_clk), 0);
    check(rise_cnt == 0, "R1 no pulse", rise_cnt, 0);

    // R2: each divided rate, three pulses
    for (int c = 1; c < 8; c++) run_code(c, "R2");
    run_code(0, "R3");

    // R4 / R8: rate changes right after falls
    rate_sel = 3'd2;
    push(4, 4, "R4"); push(4, 4, "R4");
    push(256, 258, "R8");
    push(1, 1, "R3"); push(1, 1, "R3");
    push(8, 8, "R8"); push(8, 0, "R4");
    clk_en = 1'b1;
    wait_fall(2); rate_sel = 3'd5;
    wait_fall(1); rate_sel = 3'd0;
    wait_fall(2); rate_sel = 3'd3;
    wait_fall(2); clk_en = 1'b0;
    quiet(20, "R4");

    // R4: change during a high phase
    rate_sel = 3'd4;
    push(16, 16, "R4"); push(2, 2, "R4"); push(2, 0, "R4");
    base = rise_cnt;
    clk_en = 1'b1;
    wait (rise_cnt >= base + 1);
    rate_sel = 3'd1;
    wait_fall(3);
    clk_en = 1'b0;
    quiet(20, "R4");

    // R7 restart latency, R5 stop mid-high
    rate_sel = 3'd3;
    push(8, 8, "R5"); push(8, 0, "R5");
    @(negedge ref_clk); #1;
    base = rise_cnt;
    clk_en = 1'b1;
    @(posedge ref_clk); #1;
    check(host_clk == 1'b1, "R7 divided start", int'(host_clk), 1);
    wait (rise_cnt >= base + 2);
    clk_en = 1'b0;
    quiet(20, "R5");

    // R7 / R3 pass-through latency and shape
    rate_sel = 3'd0;
    push(1, 1, "R3"); push(1, 1, "R3"); push(1, 0, "R5");
    @(negedge ref_clk); #1;
    clk_en = 1'b1;
    @(posedge ref_clk); #1;
    check(host_clk == 1'b0, "R7 bypass wait", int'(host_clk), 0);
    @(posedge ref_clk); #1;
    check(host_clk == 1'b1, "R7 bypass start", int'(host_clk), 1);
    @(negedge ref_clk); #1;
    check(host_clk == 1'b0, "R3 follows low", int'(host_clk), 0);
    @(posedge ref_clk); #1;
    check(host_clk == 1'b1, "R3 follows high", int'(host_clk), 1);
    clk_en = 1'b0;
    quiet(10, "R5");

    // R6: doze without and with doze_run_en
    rate_sel = 3'd2;
    push(4, 4, "R6"); push(4, 0, "R6");
    clk_en = 1'b1;
    wait_fall(2);
    doze_active = 1'b1;
    quiet(20, "R6");
    push(4, 4, "R6"); push(4, 0, "R6");
    doze_run_en = 1'b1;
    wait_fall(2);
    doze_run_en = 1'b0;
    quiet(20, "R6");
    clk_en = 1'b0;
    doze_active = 1'b0;
    quiet(10, "R1");

    check(hi_q.size() == 0, "R2 all pulses seen", hi_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule